// File: doc/BRIEF.md
# Timestamp Result Serializer with Difference ALU

This block sits between a channel's timestamp buffer and a one-bit result line. A free-running word sequencer runs continuously. Once per word cycle it issues a load pulse. If the buffer holds an entry at that moment, the oldest entry is popped. The ALU then forms event time minus current sync time minus a calibration offset. The result is cut to the selected length and parallel-loaded into a shift register.

The word goes out as a zero tag bit, then the result bits least significant first, so the sign bit (the top kept bit) is last. The strobe is low for the whole word and high for the two separating bit times. If the load pulse finds the buffer empty, the strobe stays high and the data line stays low for that whole word cycle.

A bit time is two `clk` cycles. In normal mode `bit_clk` has a period of one bit time and data changes on its rising edge. In double-data-rate mode `bit_clk` runs at half that frequency and data changes on both of its edges, so the bit rate is unchanged.

The sequencer has four states, each lasting one bit time, and `ST_DATA` lasts as many bit times as the result length:
- `ST_GAP_A`: the first separating bit. It advances to `ST_GAP_B`.
- `ST_GAP_B`: the second separating bit, which carries the load pulse. It advances to `ST_TAG`.
- `ST_TAG`: the tag bit. It advances to `ST_DATA`.
- `ST_DATA`: the result bits. It stays here until the last bit, then returns to `ST_GAP_A`.

Reset enters `ST_GAP_A`.

Top module: `ts_result_serializer`

## Requirements
- R1: `len_code` selects the result length L: 0→8, 1→16, 2→24, 3→32, 4→40 bits, and codes 5, 6 and 7 give 40 bits. The code is sampled at the load pulse.
- R2: A word begins when the strobe goes low. Its first bit is the tag and is always 0. Then come L result bits, bit 0 first and bit L-1 last.
- R3: After the last result bit the strobe is high. Between back-to-back words it is high for exactly 2 bit times. The data line is 0 whenever the strobe is high.
- R4: The word cycle is free running and lasts L+3 bit times, with one load pulse per cycle. With data always available, `fifo_pop` pulses repeat every 2·(L+3) clocks. A pop occurs only when the buffer is not empty, and the strobe falls on the bit that follows the pop.
- R5: When the load pulse finds `fifo_empty` high, there is no pop, and the strobe stays high for the whole word cycle.
- R6: The transmitted value is (event − sync − sign-extended calibration word) modulo 2^40, keeping its low L bits.
- R7: The calibration word is selected by index k = {sync_pol, evt_pol}. Word k is `cal_words[16k+15:16k]` and is treated as signed.
- R8: `sync_ts` is sampled at the load pulse. An event older than that sync time yields a negative result whose last transmitted bit is 1.
- R9: A bit time is 2 clocks, and data changes only at bit boundaries. In normal mode `bit_clk` rises at each boundary, with a period of 2 clocks. In DDR mode `bit_clk` toggles at each boundary, with a period of 4 clocks.
- R10: During and right after reset, the strobe is high, the data is 0 and no pop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (two cycles per bit) |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_rdata | input | 40 | Oldest buffered event timestamp (show-ahead) |
| fifo_empty | input | 1 | Buffer holds no entry |
| fifo_full | input | 1 | Buffer holds its maximum number of entries |
| sync_ts | input | 40 | Latest sync timestamp |
| cal_words | input | 64 | Four signed 16-bit calibration words, word k at bits 16k+15:16k |
| sync_pol | input | 1 | Edge polarity used for sync capture |
| evt_pol | input | 1 | Edge polarity used for event capture |
| len_code | input | 3 | Result length select |
| ddr_en | input | 1 | Double-data-rate bit clock enable |
| bit_clk | output | 1 | Result bit clock |
| frame_strobe | output | 1 | Low during tag and result bits, high otherwise |
| sdata | output | 1 | Serial result data |
| fifo_pop | output | 1 | One-clock pop pulse to the buffer |

## Verification
On every cycle the assertions check four things:
- the tag bit is zero, and the data line is quiet while the strobe is high;
- a word start follows every pop, and an empty load keeps the strobe high;
- data changes only on the proper `bit_clk` edge in each clock mode;
- a full buffer is never reported empty.

Only the bench scenarios can show the arithmetic: the subtraction, the calibration word chosen for each polarity pair, the truncation at each length code, and the negative results that a sync arriving after an event produces. The same holds for the exact word-cycle period and for the gap of two bits between back-to-back words.

// File: rtl/ts_ser_pkg.sv
`timescale 1ns/1ps
package ts_ser_pkg;

    localparam int LCODE_W = 3;
    localparam int NUM_CAL = 4;

    typedef enum logic [1:0] {
        ST_GAP_A = 2'd0,
        ST_GAP_B = 2'd1,
        ST_TAG   = 2'd2,
        ST_DATA  = 2'd3
    } ser_state_t;

endpackage

// File: rtl/ts_ser_len_dec.sv
`timescale 1ns/1ps
module ts_ser_len_dec
    import ts_ser_pkg::*;
#(
    parameter int TS_W     = 40,
    parameter int LEN_STEP = 8,
    parameter int CNT_W    = $clog2(TS_W)
) (
    input  logic [LCODE_W-1:0] len_code,
    output logic [CNT_W-1:0]   len_m1
);

    localparam int NCODES = TS_W / LEN_STEP;

    // Codes beyond the defined set fall back to the full width.
    always_comb begin
        if (int'(len_code) < NCODES) begin
            len_m1 = CNT_W'((int'(len_code) + 1) * LEN_STEP - 1);
        end else begin
            len_m1 = CNT_W'(TS_W - 1);
        end
    end

endmodule

// File: rtl/ts_ser_alu.sv
`timescale 1ns/1ps
module ts_ser_alu
    import ts_ser_pkg::*;
#(
    parameter int TS_W  = 40,
    parameter int CAL_W = 16
) (
    input  logic [TS_W-1:0]          evt_ts,
    input  logic [TS_W-1:0]          sync_ts,
    input  logic [NUM_CAL*CAL_W-1:0] cal_words,
    input  logic                     sync_pol,
    input  logic                     evt_pol,
    output logic [TS_W-1:0]          result
);

    logic [CAL_W-1:0] cal_arr [NUM_CAL];
    logic [1:0]       cal_sel;
    logic [TS_W-1:0]  cal_ext;

    for (genvar k = 0; k < NUM_CAL; k++) begin : g_cal
        assign cal_arr[k] = cal_words[k*CAL_W +: CAL_W];
    end

    assign cal_sel = {sync_pol, evt_pol};
    assign cal_ext = {{(TS_W-CAL_W){cal_arr[cal_sel][CAL_W-1]}}, cal_arr[cal_sel]};
    assign result  = evt_ts - sync_ts - cal_ext;

endmodule

// File: rtl/ts_ser_fsm.sv
`timescale 1ns/1ps
module ts_ser_fsm
    import ts_ser_pkg::*;
#(
    parameter int TS_W  = 40,
    parameter int CNT_W = $clog2(TS_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             buf_empty,
    input  logic [TS_W-1:0]  load_val,
    input  logic [CNT_W-1:0] len_m1,
    output logic             strobe,
    output logic             sdata,
    output logic             load
);

    localparam logic [CNT_W-1:0] CNT_ZERO = '0;
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    ser_state_t       state, state_nxt;
    logic             valid_q;
    logic [TS_W-1:0]  shreg;
    logic [CNT_W-1:0] cnt;
    logic             in_word;

    // Next-state logic: every state lasts one bit time except ST_DATA.
    always_comb begin
        state_nxt = state;
        if (tick) begin
            unique case (state)
                ST_GAP_A: state_nxt = ST_GAP_B;
                ST_GAP_B: state_nxt = ST_TAG;
                ST_TAG:   state_nxt = ST_DATA;
                ST_DATA:  state_nxt = (cnt == CNT_ZERO) ? ST_GAP_A : ST_DATA;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_GAP_A;
        end else begin
            state <= state_nxt;
        end
    end

    // The load pulse comes once per word cycle, on the last gap bit.
    assign load = tick && (state == ST_GAP_B) && !buf_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            shreg   <= '0;
            cnt     <= CNT_ZERO;
        end else if (tick) begin
            if (state == ST_GAP_B) begin
                valid_q <= !buf_empty;
                shreg   <= load_val;
                cnt     <= len_m1;
            end else if ((state == ST_DATA) && (cnt != CNT_ZERO)) begin
                shreg <= shreg >> 1;
                cnt   <= cnt - CNT_ONE;
            end
        end
    end

    // Output decode
    always_comb begin
        in_word = valid_q && ((state == ST_TAG) || (state == ST_DATA));
        strobe  = !in_word;
        sdata   = valid_q && (state == ST_DATA) && shreg[0];
    end

    AST_TAG_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe) |-> !sdata); // R2

    AST_GAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |-> !sdata); // R3

    AST_FRAME_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> $fell(strobe)); // R4

    AST_EMPTY_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (state == ST_GAP_B) && buf_empty) |=> strobe); // R5

endmodule

// File: rtl/ts_result_serializer.sv
`timescale 1ns/1ps
module ts_result_serializer
    import ts_ser_pkg::*;
#(
    parameter int TS_W     = 40,
    parameter int CAL_W    = 16,
    parameter int LEN_STEP = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TS_W-1:0]          fifo_rdata,
    input  logic                     fifo_empty,
    input  logic                     fifo_full,
    input  logic [TS_W-1:0]          sync_ts,
    input  logic [NUM_CAL*CAL_W-1:0] cal_words,
    input  logic                     sync_pol,
    input  logic                     evt_pol,
    input  logic [LCODE_W-1:0]       len_code,
    input  logic                     ddr_en,
    output logic                     bit_clk,
    output logic                     frame_strobe,
    output logic                     sdata,
    output logic                     fifo_pop
);

    localparam int CNT_W = $clog2(TS_W);

    logic             ph;
    logic             ddr_clk;
    logic             tick;
    logic [CNT_W-1:0] len_m1;
    logic [TS_W-1:0]  alu_res;

    // Two clocks per bit: the second clock of each bit is the tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph      <= 1'b0;
            ddr_clk <= 1'b0;
        end else begin
            ph <= !ph;
            if (ph) begin
                ddr_clk <= !ddr_clk;
            end
        end
    end

    assign tick    = ph;
    assign bit_clk = ddr_en ? ddr_clk : !ph;

    ts_ser_len_dec #(.TS_W(TS_W), .LEN_STEP(LEN_STEP), .CNT_W(CNT_W)) u_len (
        .len_code (len_code),
        .len_m1   (len_m1)
    );

    ts_ser_alu #(.TS_W(TS_W), .CAL_W(CAL_W)) u_alu (
        .evt_ts    (fifo_rdata),
        .sync_ts   (sync_ts),
        .cal_words (cal_words),
        .sync_pol  (sync_pol),
        .evt_pol   (evt_pol),
        .result    (alu_res)
    );

    ts_ser_fsm #(.TS_W(TS_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .buf_empty (fifo_empty),
        .load_val  (alu_res),
        .len_m1    (len_m1),
        .strobe    (frame_strobe),
        .sdata     (sdata),
        .load      (fifo_pop)
    );

    AST_BITCLK_SDR: assert property (@(posedge clk) disable iff (!rst_n)
        (!ddr_en && !$past(ddr_en) && (sdata != $past(sdata))) |->
        (bit_clk && !$past(bit_clk))); // R9

    AST_BITCLK_DDR: assert property (@(posedge clk) disable iff (!rst_n)
        (ddr_en && $past(ddr_en) && (sdata != $past(sdata))) |->
        (bit_clk != $past(bit_clk))); // R9

    AST_FULL_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> !fifo_empty); // R4

endmodule

// File: tb/ts_result_serializer_test.sv
`timescale 1ns/1ps
module ts_result_serializer_test;

    localparam int TS_W  = 40;
    localparam int CAL_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [TS_W-1:0]   fifo_rdata = '0;
    logic              fifo_empty = 1'b1;
    logic              fifo_full = 1'b0;
    logic [TS_W-1:0]   sync_ts = '0;
    logic [4*CAL_W-1:0] cal_words = {16'h0400, 16'hFF80, 16'h0123, 16'h0011};
    logic              sync_pol = 1'b0;
    logic              evt_pol = 1'b0;
    logic [2:0]        len_code = 3'd4;
    logic              ddr_en = 1'b0;
    logic              bit_clk, frame_strobe, sdata, fifo_pop;

    always #2.5 clk = ~clk;

    ts_result_serializer uut (
        .clk(clk), .rst_n(rst_n), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .fifo_full(fifo_full), .sync_ts(sync_ts), .cal_words(cal_words),
        .sync_pol(sync_pol), .evt_pol(evt_pol), .len_code(len_code), .ddr_en(ddr_en),
        .bit_clk(bit_clk), .frame_strobe(frame_strobe), .sdata(sdata), .fifo_pop(fifo_pop)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    logic [TS_W-1:0] fq[$];
    logic [TS_W-1:0] expq[$];
    int              expl[$];

    logic            pop_pend = 1'b0;
    logic            prev_bclk = 1'b1;
    logic            prev_sdata = 1'b0;
    logic            in_frame = 1'b0;
    logic            check_neg = 1'b0;
    logic            sync_run = 1'b0;
    logic [TS_W-1:0] rx = '0;
    int idx = 0, gap = 0, frames_scn = 0;
    int last_pop_t = -1, last_bit_t = -1, bit_skip = 3;
    int quiet_err = 0, bit_err = 0, lowcnt = 0, popcnt = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int len_of(input logic [2:0] code);
        return (code < 3'd5) ? 8 * (int'(code) + 1) : 40;
    endfunction

    function automatic logic [TS_W-1:0] expect_val(input logic [TS_W-1:0] ev, input logic [TS_W-1:0] sy,
                                                   input logic sp, input logic ep, input int l);
        logic [15:0]     c;
        logic [TS_W-1:0] r, m;
        c = cal_words[{sp, ep}*16 +: 16];
        r = ev - sy - {{24{c[15]}}, c};
        m = (l == 40) ? '1 : ((40'd1 << l) - 40'd1);
        return r & m;
    endfunction

    task automatic upd();
        fifo_empty = (fq.size() == 0);
        fifo_full  = (fq.size() == 15);
        fifo_rdata = (fq.size() == 0) ? '0 : fq[0];
    endtask

    always @(posedge clk) cyc++;

    always @(posedge clk) begin
        #1;
        if (sync_run) sync_ts = sync_ts + 40'd3;
    end

    // Buffer model and receiver, sampled mid-cycle
    always @(negedge clk) begin
        logic nb;
        if (pop_pend && fq.size() > 0) begin
            void'(fq.pop_front());
            upd();
        end
        pop_pend = fifo_pop;
        if (!frame_strobe) lowcnt++;
        if (fifo_pop) begin
            int l;
            popcnt++;
            l = len_of(len_code);
            chk(!fifo_empty, "R4 pop while empty", fifo_empty, 0);
            expq.push_back(expect_val(fq[0], sync_ts, sync_pol, evt_pol, l));
            expl.push_back(l);
            if (last_pop_t >= 0)
                chk(cyc - last_pop_t == 2 * (l + 3), "R4 word period", cyc - last_pop_t, 2 * (l + 3));
            last_pop_t = cyc;
        end
        nb = ddr_en ? (bit_clk != prev_bclk) : (bit_clk && !prev_bclk);
        if (rst_n && bit_skip == 0 && !nb && (sdata != prev_sdata)) bit_err++;
        prev_bclk  = bit_clk;
        prev_sdata = sdata;
        if (nb && rst_n) begin
            if (bit_skip > 0) bit_skip--;
            else if (cyc - last_bit_t != 2) bit_err++;
            last_bit_t = cyc;
            if (!frame_strobe) begin
                if (!in_frame) begin
                    in_frame = 1'b1;
                    idx = 0;
                    rx = '0;
                    chk(sdata == 1'b0, "R2 tag bit", sdata, 0);
                    if (frames_scn > 0) chk(gap == 2, "R3 gap bits", gap, 2);
                end else begin
                    if (idx < TS_W) rx[idx] = sdata;
                    idx++;
                end
            end else begin
                if (sdata) quiet_err++;
                if (in_frame) begin
                    logic [TS_W-1:0] e;
                    int l;
                    in_frame = 1'b0;
                    e = (expq.size() > 0) ? expq.pop_front() : '1;
                    l = (expl.size() > 0) ? expl.pop_front() : -1;
                    chk(idx == l, "R1 word length", idx, l);
                    chk(rx == e, "R6 R7 result value", rx, e);
                    if (check_neg) chk(rx[l-1] == 1'b1, "R8 negative sign", rx[l-1], 1);
                    frames_scn++;
                    gap = 1;
                end else begin
                    gap++;
                end
            end
        end
    end

    task automatic wait_quiet();
        int t;
        t = 0;
        while ((fq.size() != 0 || expq.size() != 0 || in_frame) && t < 5000) begin
            @(posedge clk);
            t++;
        end
        repeat (100) @(posedge clk);
        #1;
    endtask

    task automatic run_cfg(input logic [2:0] code, input logic ddr, input logic sp, input logic ep,
                           input int n, input logic neg);
        wait_quiet();
        len_code = code;
        ddr_en = ddr;
        sync_pol = sp;
        evt_pol = ep;
        check_neg = neg;
        last_pop_t = -1;
        frames_scn = 0;
        bit_skip = 3;
        for (int i = 0; i < n; i++) begin
            logic [63:0] w;
            w = {$urandom(), $urandom()};
            fq.push_back(neg ? TS_W'(i * 7) : w[TS_W-1:0]);
        end
        upd();
    endtask

    initial begin
        #(5.0 * 190000);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(frame_strobe == 1'b1 && sdata == 1'b0 && fifo_pop == 1'b0, "R10 reset outputs",
            {frame_strobe, sdata, fifo_pop}, 3'b100);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        chk(frame_strobe == 1'b1 && sdata == 1'b0 && fifo_pop == 1'b0, "R10 after reset",
            {frame_strobe, sdata, fifo_pop}, 3'b100);

        // R5: empty buffer keeps every word cycle idle
        lowcnt = 0; popcnt = 0;
        repeat (300) @(posedge clk);
        chk(lowcnt == 0, "R5 idle strobe low count", lowcnt, 0);
        chk(popcnt == 0, "R5 idle pop count", popcnt, 0);

        // Sweep of length codes, clock modes and calibration selections
        sync_ts = 40'h12_3456_789A;
        for (int c = 0; c < 8; c++) begin
            for (int d = 0; d < 2; d++) begin
                for (int p = 0; p < 4; p++) begin
                    run_cfg(3'(c), 1'(d), 1'(p >> 1), 1'(p & 1), 3, 1'b0);
                end
            end
        end

        // R8: sync moves every clock; events predate it
        wait_quiet();
        sync_ts = 40'd1000;
        sync_run = 1'b1;
        run_cfg(3'd4, 1'b0, 1'b1, 1'b0, 3, 1'b1);
        run_cfg(3'd1, 1'b1, 1'b0, 1'b1, 3, 1'b1);
        wait_quiet();
        sync_run = 1'b0;
        check_neg = 1'b0;

        // R5 again at the shortest length
        len_code = 3'd0;
        repeat (50) @(posedge clk);
        lowcnt = 0; popcnt = 0;
        repeat (200) @(posedge clk);
        chk(lowcnt == 0, "R5 idle short length", lowcnt, 0);

        chk(expq.size() == 0, "R4 all words sent", expq.size(), 0);
        chk(quiet_err == 0, "R3 data low in gaps", quiet_err, 0);
        chk(bit_err == 0, "R9 bit clock timing", bit_err, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule